// File: doc/BRIEF.md
# Low-Power Mode Entry Controller

This block chooses the low-power state a small processor system falls into when its core issues a sleep request, and it brings the system back to normal operation when a wake event arrives. Three control bits written by software steer the choice: standby enable, deep-standby enable and port retention. Two status inputs can override the choice: one says the watchdog is running in watchdog mode, the other says at least one wake source is armed.

The registered mode output drives the clock and power logic around the block. The port-hold output freezes the general-purpose pins while the system is in either standby state. If retention is enabled, the pins stay frozen after a deep-standby exit until software releases them. On a deep-standby exit with the external bus in use, the external-bus reset output returns the bus pins to their reset state for a fixed number of cycles, whatever the retention setting.

Top module: `lp_entry_ctrl`

## Requirements
- R1: After reset, pwr_mode is 0 (run), cfg_q is 0, port_hold is 0 and xbus_reset is 0.
- R2: A cycle with cfg_wr high loads cfg_wdata into the control bits, which appear on cfg_q in the following cycle: bit 0 is standby enable, bit 1 is deep-standby enable, bit 2 is port retention.
- R3: The mode encoding is run=0, sleep=1, standby=2, deep standby=3. In run, a sleep_req with standby enable at 0 moves pwr_mode to 1 on the next cycle, whatever the deep-standby bit holds.
- R4: In run, a sleep_req with standby enable at 1 and deep-standby enable at 0 moves pwr_mode to 2 on the next cycle.
- R5: In run, a sleep_req with standby enable and deep-standby enable both at 1 moves pwr_mode to 3 on the next cycle when wake_armed is 0, and to 2 when wake_armed is 1.
- R6: In run, a sleep_req while wdt_mode is 1 moves pwr_mode to 1 on the next cycle, whatever the control bits hold.
- R7: A sleep_req while pwr_mode is not 0 has no effect on pwr_mode.
- R8: A wake_evt while pwr_mode is 1, 2 or 3 returns pwr_mode to 0 on the next cycle. A wake_evt in run has no effect.
- R9: Leaving deep standby leaves the deep-standby bit (cfg_q bit 1) at 1. Only a write clears it.
- R10: port_hold is 1 in every cycle in which pwr_mode is 2 or 3.
- R11: With retention (bit 2) at 0, port_hold falls in the same cycle that pwr_mode returns to 0 from deep standby or standby.
- R12: With retention at 1 when deep standby is left, port_hold stays 1 after pwr_mode returns to 0. It falls in the cycle after a write with cfg_wdata bit 2 at 0.
- R13: On an exit from deep standby with ext_bus_mode at 1, xbus_reset is 1 for XBUS_RST_CYCLES cycles (default 2), starting in the cycle pwr_mode returns to 0. It stays 0 on exits from sleep or standby and when ext_bus_mode is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Write strobe for the control bits |
| cfg_wdata | input | 3 | Write data: bit 0 standby enable, bit 1 deep-standby enable, bit 2 retention |
| sleep_req | input | 1 | One-cycle sleep request from the core |
| wake_evt | input | 1 | Wake or interrupt event |
| wdt_mode | input | 1 | Watchdog is running in watchdog mode |
| wake_armed | input | 1 | At least one wake source is armed |
| ext_bus_mode | input | 1 | External extended-bus mode is active |
| cfg_q | output | 3 | Current control bits |
| pwr_mode | output | 2 | Current power mode: 0 run, 1 sleep, 2 standby, 3 deep standby |
| port_hold | output | 1 | Freeze general-purpose port states |
| xbus_reset | output | 1 | Force external-bus pins to their reset values |

## Verification
The assertions check on every cycle the properties that depend only on one cycle and the next. These are: the target mode chosen after a request in run, the watchdog override, that requests outside run are ignored, the return to run after a wake, port hold during both standby states, and that a bus-reset pulse begins only right after deep standby. Some behaviours only the directed scenarios can show, because they depend on longer histories: that the deep-standby bit survives an exit, that retained port hold lasts until a later write clears it, and the exact length of the bus-reset pulse.

// File: rtl/lp_pkg.sv
package lp_pkg;

    typedef enum logic [1:0] {
        LP_RUN   = 2'd0,
        LP_SLEEP = 2'd1,
        LP_STBY  = 2'd2,
        LP_DEEP  = 2'd3
    } lp_mode_e;

    // Bit 2 retention, bit 1 deep-standby enable, bit 0 standby enable
    typedef struct packed {
        logic retain;
        logic deep_en;
        logic stby_en;
    } lp_cfg_t;

    localparam int unsigned LP_CFG_W = $bits(lp_cfg_t);

    function automatic logic lp_is_standby(input lp_mode_e m);
        return (m == LP_STBY) || (m == LP_DEEP);
    endfunction

endpackage

// File: rtl/lp_ctrl_regs.sv
module lp_ctrl_regs
    import lp_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    wr,
    input  lp_cfg_t wdata,
    output lp_cfg_t cfg_q
);

    typedef struct packed {
        lp_cfg_t cfg;
    } regs_t;

    regs_t r_d, r_q;

    // Bits change only on a write; a wake never touches them
    always_comb begin
        r_d = r_q;
        if (wr) begin
            r_d.cfg = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign cfg_q = r_q.cfg;

endmodule

// File: rtl/lp_mode_select.sv
module lp_mode_select
    import lp_pkg::*;
(
    input  lp_mode_e cur_mode,
    input  logic     sleep_req,
    input  logic     wake_evt,
    input  lp_cfg_t  cfg,
    input  logic     wdt_mode,
    input  logic     wake_armed,
    output lp_mode_e nxt_mode,
    output logic     exit_deep,
    output logic     exit_any
);

    lp_mode_e target;

    // Target state for a request made in run
    always_comb begin
        if (wdt_mode || !cfg.stby_en) begin
            target = LP_SLEEP;
        end else if (cfg.deep_en && !wake_armed) begin
            target = LP_DEEP;
        end else begin
            target = LP_STBY;
        end
    end

    always_comb begin
        nxt_mode  = cur_mode;
        exit_deep = 1'b0;
        exit_any  = 1'b0;
        if (cur_mode == LP_RUN) begin
            if (sleep_req) begin
                nxt_mode = target;
            end
        end else if (wake_evt) begin
            nxt_mode  = LP_RUN;
            exit_any  = 1'b1;
            exit_deep = (cur_mode == LP_DEEP);
        end
    end

endmodule

// File: rtl/lp_hold_ctrl.sv
module lp_hold_ctrl
    import lp_pkg::*;
#(
    parameter int unsigned XBUS_RST_CYCLES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  lp_mode_e mode_d,
    input  logic     exit_deep,
    input  logic     retain_q,
    input  logic     retain_clr,
    input  logic     ext_bus_mode,
    output logic     port_hold,
    output logic     xbus_reset
);

    localparam int unsigned CNT_W = $clog2(XBUS_RST_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(XBUS_RST_CYCLES);

    typedef struct packed {
        logic             keep;
        logic             hold;
        logic [CNT_W-1:0] xcnt;
    } hold_t;

    hold_t h_d, h_q;

    always_comb begin
        h_d = h_q;

        // Retained hold after a deep exit; a write of retain=0 wins
        if (exit_deep && retain_q) begin
            h_d.keep = 1'b1;
        end
        if (retain_clr) begin
            h_d.keep = 1'b0;
        end

        h_d.hold = lp_is_standby(mode_d) || h_d.keep;

        // Bus reset pulse counter
        if (exit_deep && ext_bus_mode) begin
            h_d.xcnt = CNT_LOAD;
        end else if (h_q.xcnt != '0) begin
            h_d.xcnt = h_q.xcnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_q <= '0;
        end else begin
            h_q <= h_d;
        end
    end

    assign port_hold  = h_q.hold;
    assign xbus_reset = (h_q.xcnt != '0);

endmodule

// File: rtl/lp_entry_ctrl.sv
module lp_entry_ctrl
    import lp_pkg::*;
#(
    parameter int unsigned XBUS_RST_CYCLES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_wr,
    input  logic [2:0] cfg_wdata,
    input  logic       sleep_req,
    input  logic       wake_evt,
    input  logic       wdt_mode,
    input  logic       wake_armed,
    input  logic       ext_bus_mode,
    output logic [2:0] cfg_q,
    output logic [1:0] pwr_mode,
    output logic       port_hold,
    output logic       xbus_reset
);

    typedef struct packed {
        lp_mode_e mode;
    } state_t;

    state_t  s_d, s_q;
    lp_cfg_t cfg_cur;
    lp_cfg_t cfg_new;
    lp_mode_e sel_mode;
    logic    exit_deep;
    logic    exit_any;

    assign cfg_new = lp_cfg_t'(cfg_wdata);

    lp_ctrl_regs u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (cfg_wr),
        .wdata (cfg_new),
        .cfg_q (cfg_cur)
    );

    lp_mode_select u_sel (
        .cur_mode   (s_q.mode),
        .sleep_req  (sleep_req),
        .wake_evt   (wake_evt),
        .cfg        (cfg_cur),
        .wdt_mode   (wdt_mode),
        .wake_armed (wake_armed),
        .nxt_mode   (sel_mode),
        .exit_deep  (exit_deep),
        .exit_any   (exit_any)
    );

    always_comb begin
        s_d      = s_q;
        s_d.mode = sel_mode;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.mode <= LP_RUN;
        end else begin
            s_q <= s_d;
        end
    end

    lp_hold_ctrl #(
        .XBUS_RST_CYCLES (XBUS_RST_CYCLES)
    ) u_hold (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_d       (s_d.mode),
        .exit_deep    (exit_deep),
        .retain_q     (cfg_cur.retain),
        .retain_clr   (cfg_wr && !cfg_new.retain),
        .ext_bus_mode (ext_bus_mode),
        .port_hold    (port_hold),
        .xbus_reset   (xbus_reset)
    );

    logic exit_unused;
    assign exit_unused = exit_any;

    assign cfg_q    = cfg_cur;
    assign pwr_mode = s_q.mode;

endmodule

// File: rtl/lp_entry_ctrl_chk.sv
module lp_entry_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sleep_req,
    input logic       wake_evt,
    input logic       wdt_mode,
    input logic       wake_armed,
    input logic [2:0] cfg_q,
    input logic [1:0] pwr_mode,
    input logic       port_hold,
    input logic       xbus_reset
);

    // R3
    sleep_when_no_stby_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_mode == 2'd0 && sleep_req && !cfg_q[0]) |=> (pwr_mode == 2'd1));

    // R5
    armed_blocks_deep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_mode == 2'd0 && sleep_req && wake_armed) |=> (pwr_mode != 2'd3));

    // R6
    wdt_forces_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_mode == 2'd0 && sleep_req && wdt_mode) |=> (pwr_mode == 2'd1));

    // R7
    req_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_mode != 2'd0 && !wake_evt) |=> $stable(pwr_mode));

    // R8
    wake_to_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_mode != 2'd0 && wake_evt) |=> (pwr_mode == 2'd0));

    // R8
    run_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_mode == 2'd0 && !sleep_req) |=> (pwr_mode == 2'd0));

    // R10
    hold_in_standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_mode[1]) |-> port_hold);

    // R13
    xbus_after_deep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xbus_reset) |-> ($past(pwr_mode) == 2'd3 && pwr_mode == 2'd0));

endmodule

bind lp_entry_ctrl lp_entry_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sleep_req  (sleep_req),
    .wake_evt   (wake_evt),
    .wdt_mode   (wdt_mode),
    .wake_armed (wake_armed),
    .cfg_q      (cfg_q),
    .pwr_mode   (pwr_mode),
    .port_hold  (port_hold),
    .xbus_reset (xbus_reset)
);

// File: tb/sim_lp_entry_ctrl.sv
`timescale 1ns/1ps
module sim_lp_entry_ctrl;

    localparam int NRST = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [2:0] cfg_wdata = '0;
    logic       sleep_req = 1'b0;
    logic       wake_evt = 1'b0;
    logic       wdt_mode = 1'b0;
    logic       wake_armed = 1'b0;
    logic       ext_bus_mode = 1'b0;
    logic [2:0] cfg_q;
    logic [1:0] pwr_mode;
    logic       port_hold;
    logic       xbus_reset;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    lp_entry_ctrl #(.XBUS_RST_CYCLES(NRST)) u0 (
        .clk (clk), .rst_n (rst_n), .cfg_wr (cfg_wr), .cfg_wdata (cfg_wdata),
        .sleep_req (sleep_req), .wake_evt (wake_evt), .wdt_mode (wdt_mode),
        .wake_armed (wake_armed), .ext_bus_mode (ext_bus_mode), .cfg_q (cfg_q),
        .pwr_mode (pwr_mode), .port_hold (port_hold), .xbus_reset (xbus_reset)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Each pulse task drives after a falling edge; outputs settle after the
    // next rising edge and are sampled at the following falling edge.
    task automatic write_cfg(input logic [2:0] v);
        @(negedge clk); cfg_wr = 1'b1; cfg_wdata = v;
        @(negedge clk); cfg_wr = 1'b0;
    endtask

    task automatic pulse_sleep();
        @(negedge clk); sleep_req = 1'b1;
        @(negedge clk); sleep_req = 1'b0;
    endtask

    task automatic pulse_wake();
        @(negedge clk); wake_evt = 1'b1;
        @(negedge clk); wake_evt = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 mode", pwr_mode, 0);
        chk("R1 cfg", cfg_q, 0);
        chk("R1 hold", port_hold, 0);
        chk("R1 xbus", xbus_reset, 0);
    endtask

    task automatic t_cfg();
        write_cfg(3'b101);
        chk("R2 cfg", cfg_q, 5);
        write_cfg(3'b000);
        chk("R2 cfg clr", cfg_q, 0);
    endtask

    task automatic t_sleep();
        write_cfg(3'b010);
        pulse_sleep();
        chk("R3 sleep", pwr_mode, 1);
        chk("R3 no hold", port_hold, 0);
        pulse_sleep();
        write_cfg(3'b011);
        pulse_sleep();
        chk("R7 ignored", pwr_mode, 1);
        pulse_wake();
        chk("R8 wake", pwr_mode, 0);
        chk("R13 no xbus from sleep", xbus_reset, 0);
        pulse_wake();
        chk("R8 wake in run", pwr_mode, 0);
    endtask

    task automatic t_standby();
        write_cfg(3'b001);
        pulse_sleep();
        chk("R4 standby", pwr_mode, 2);
        chk("R10 hold stby", port_hold, 1);
        pulse_wake();
        chk("R11 hold off stby exit", port_hold, 0);
        chk("R8 run", pwr_mode, 0);
    endtask

    task automatic t_deep_armed();
        write_cfg(3'b011);
        wake_armed = 1'b1;
        pulse_sleep();
        chk("R5 armed standby", pwr_mode, 2);
        pulse_wake();
        wake_armed = 1'b0;
    endtask

    task automatic t_wdt();
        write_cfg(3'b011);
        wdt_mode = 1'b1;
        pulse_sleep();
        chk("R6 wdt", pwr_mode, 1);
        pulse_wake();
        wdt_mode = 1'b0;
    endtask

    task automatic t_deep_noretain();
        write_cfg(3'b011);
        ext_bus_mode = 1'b0;
        pulse_sleep();
        chk("R5 deep", pwr_mode, 3);
        chk("R10 hold deep", port_hold, 1);
        pulse_wake();
        chk("R8 deep exit", pwr_mode, 0);
        chk("R11 hold drops", port_hold, 0);
        chk("R13 no xbus", xbus_reset, 0);
        chk("R9 deep bit", cfg_q[1], 1);
    endtask

    task automatic t_deep_retain();
        write_cfg(3'b111);
        ext_bus_mode = 1'b1;
        pulse_sleep();
        chk("R5 deep", pwr_mode, 3);
        pulse_wake();
        chk("R12 hold kept", port_hold, 1);
        chk("R13 xbus on", xbus_reset, 1);
        for (int i = 1; i < NRST; i++) begin
            @(negedge clk);
            chk("R13 xbus held", xbus_reset, 1);
        end
        @(negedge clk);
        chk("R13 xbus off", xbus_reset, 0);
        chk("R12 hold still", port_hold, 1);
        chk("R9 deep bit kept", cfg_q[1], 1);
        write_cfg(3'b011);
        chk("R12 hold released", port_hold, 0);
        ext_bus_mode = 1'b0;
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                t_reset();
                rst_n = 1'b1;
                @(negedge clk);
                t_reset();
                t_cfg();
                t_sleep();
                t_standby();
                t_deep_armed();
                t_wdt();
                t_deep_noretain();
                t_deep_retain();
                done = 1'b1;
            end
            begin
                repeat (20000) @(posedge clk);
                if (!done) begin
                    checks++;
                    failures++;
                    $display("FAIL watchdog actual=hung expected=done");
                end
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule